// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Copies

This block fronts a behavioural array of one-time-programmable fuse words, 128 words of 32 bits by default, seen as 16 banks of 8. Software never reads the fuses directly. Every fuse word has a shadow copy, and bus reads of the shadow window return those copies. A reload command refreshes the whole shadow set from the fuses, one word at a time.

Burning a word is a two-step action. Software first writes the control register with the word index and the 16-bit unlock key 0x3E77. It then writes the 32-bit value to the data register, and that write starts a timed sequence: relax, program strobe, relax. The value is ORed into the fuse word, so a bit can go from 0 to 1 and never back. The durations come from a timing register in clock cycles. Any field value N gives a phase of N+1 cycles. Busy, error and reload-in-progress flags are readable in the control register.

The bus is a simple port. A read is requested for one cycle, and its data returns with a valid strobe two cycles later. Back-to-back reads are allowed.

Top module: `otp_ctrl`

## Requirements
- R1: After reset the control register (offset 0x000) reads 0, the data register (0x020) reads 0, all shadows read 0, and the timing register (0x010) reads 0x0002_1005 (program 5, relax 1, read 2).
- R2: Control layout: bits 6:0 word index, bit 8 busy, bit 9 error, bit 10 reload, bits 31:16 unlock key; other bits read 0. A write to the set alias at 0x004 ORs the written index, key, error and reload bits into the register and leaves every other bit unchanged.
- R3: A data-register write while idle with key 0x3E77 starts a program operation, and busy reads 1 on a read issued in the next cycle.
- R4: Programming ORs the data into the addressed fuse word. The shadow word keeps its old value until a reload.
- R5: A data-register write with any key other than 0x3E77 sets error (bit 9) and starts no operation.
- R6: A data-register write while busy sets error and leaves the running operation and its target word unchanged.
- R7: A write to the control register at 0x000 with bit 9 equal to 0 clears error, and with bit 9 equal to 1 keeps it.
- R8: The unlock key field reads 0 after a program operation has been accepted.
- R9: Writing 1 to bit 10 while idle copies every fuse word into its shadow. Bit 10 and busy read 1 for the whole reload, and bit 10 clears itself at the end.
- R10: A program operation keeps busy high for exactly 2*(relax+1)+(prog+1) cycles. Each word of a reload takes 2*(relax+1)+(read+1) cycles.
- R11: Timing register: bits 11:0 program strobe, bits 15:12 relax, bits 21:16 read strobe; bits 31:22 read 0.
- R12: Shadow word n reads at offset 0x400 + n*0x10 for n = 0..127. All other offsets, including unaligned ones inside that window, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request, one cycle per write |
| bus_rd | input | 1 | Read request, one cycle per read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High two cycles after a read request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that the timing register is not rewritten while an operation runs, because the length check compares against the live field values. The stimulus keeps to both: every access is issued alone, and the timing register is written only while the block is idle. Rejected writes during busy touch only the control and data registers. The waits between operations are computed from the default timing values and not polled, so every read has a known expected value for the scoreboard.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFF_CTRL     = 12'h000;
  localparam logic [BUS_AW-1:0] OFF_CTRL_SET = 12'h004;
  localparam logic [BUS_AW-1:0] OFF_TIMING   = 12'h010;
  localparam logic [BUS_AW-1:0] OFF_DATA     = 12'h020;
  localparam logic [BUS_AW-1:0] SHADOW_BASE  = 12'h400;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  localparam int BUSY_BIT      = 8;
  localparam int ERR_BIT       = 9;
  localparam int RELOAD_BIT    = 10;
  localparam int KEY_LSB       = 16;
  localparam int TIM_RELAX_LSB = 12;
  localparam int TIM_READ_LSB  = 16;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RELAX_A,
    PH_STROBE,
    PH_RELAX_B
  } phase_t;
endpackage

// File: rtl/otp_mem.sv
module otp_mem #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  // Simple dual-port array, registered read: maps onto block RAM.
  logic [WIDTH-1:0] mem [DEPTH] = '{default: '0};

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int WORDS   = 128,
  parameter int PROG_W  = 12,
  parameter int RELAX_W = 4,
  parameter int READ_W  = 6,
  localparam int AW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_prog,
  input  logic               start_reload,
  input  logic [AW-1:0]      prog_addr,
  input  logic [BUS_DW-1:0]  prog_data,
  input  logic [PROG_W-1:0]  t_prog,
  input  logic [RELAX_W-1:0] t_relax,
  input  logic [READ_W-1:0]  t_read,
  input  logic [BUS_DW-1:0]  fuse_rdata,
  output logic               busy,
  output logic               reloading,
  output logic [AW-1:0]      word_addr,
  output logic               fuse_we,
  output logic [BUS_DW-1:0]  fuse_wdata,
  output logic               shadow_we,
  output logic [BUS_DW-1:0]  shadow_wdata
);
  localparam int CW_A = (PROG_W > READ_W) ? PROG_W : READ_W;
  localparam int CW   = (CW_A > RELAX_W) ? CW_A : RELAX_W;

  phase_t              ph;
  logic                is_reload;
  logic [AW-1:0]       op_addr;
  logic [BUS_DW-1:0]   op_data;
  logic [CW-1:0]       cnt;
  logic                last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      is_reload <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      cnt       <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start_prog) begin
            ph        <= PH_RELAX_A;
            is_reload <= 1'b0;
            op_addr   <= prog_addr;
            op_data   <= prog_data;
            cnt       <= CW'(t_relax);
          end else if (start_reload) begin
            ph        <= PH_RELAX_A;
            is_reload <= 1'b1;
            op_addr   <= '0;
            cnt       <= CW'(t_relax);
          end
        end
        PH_RELAX_A: begin
          if (last) begin
            ph  <= PH_STROBE;
            cnt <= is_reload ? CW'(t_read) : CW'(t_prog);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (last) begin
            ph  <= PH_RELAX_B;
            cnt <= CW'(t_relax);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RELAX_B: begin
          if (last) begin
            if (is_reload && op_addr != AW'(WORDS - 1)) begin
              ph      <= PH_RELAX_A;
              op_addr <= op_addr + 1'b1;
              cnt     <= CW'(t_relax);
            end else begin
              ph <= PH_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // The fuse read port follows op_addr; its registered output settles
  // during the first relax cycle, before the strobe ends.
  assign busy         = (ph != PH_IDLE);
  assign reloading    = busy && is_reload;
  assign word_addr    = op_addr;
  assign fuse_we      = (ph == PH_STROBE) && last && !is_reload;
  assign fuse_wdata   = fuse_rdata | op_data;
  assign shadow_we    = (ph == PH_STROBE) && last && is_reload;
  assign shadow_wdata = fuse_rdata;

  // Busy-cycle counter used only to check the program sequence length.
  logic [31:0] len_q;
  always_ff @(posedge clk) begin
    if (rst || ph == PH_IDLE) len_q <= '0;
    else                      len_q <= len_q + 1'b1;
  end

  p_prog_len_r10: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RELAX_B && last && !is_reload)
      |-> (len_q == 32'(t_relax) * 2 + 32'(t_prog) + 32'd2));

  p_word_step_r9: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RELAX_B && last && is_reload && op_addr != AW'(WORDS - 1))
      |=> (ph == PH_RELAX_A && is_reload));
endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int WORDS     = 128,
  parameter int PROG_W    = 12,
  parameter int RELAX_W   = 4,
  parameter int READ_W    = 6,
  parameter int DEF_PROG  = 5,
  parameter int DEF_RELAX = 1,
  parameter int DEF_READ  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int AW = $clog2(WORDS);
  localparam logic [BUS_AW:0] SH_SPAN = (BUS_AW + 1)'(WORDS * 16);

  logic [AW-1:0]      word_sel_q;
  logic [15:0]        key_q;
  logic               err_q;
  logic [PROG_W-1:0]  t_prog_q;
  logic [RELAX_W-1:0] t_relax_q;
  logic [READ_W-1:0]  t_read_q;
  logic [BUS_DW-1:0]  data_q;

  logic busy, reloading, fuse_we, shadow_we;
  logic [AW-1:0]     word_addr;
  logic [BUS_DW-1:0] fuse_rdata, fuse_wdata, shadow_wdata, shadow_rdata;

  // ---------------- write decode ----------------
  logic wr_ctrl, wr_set, wr_tim, wr_data, key_ok, start_prog, start_reload;
  assign wr_ctrl      = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_set       = bus_wr && (bus_addr == OFF_CTRL_SET);
  assign wr_tim       = bus_wr && (bus_addr == OFF_TIMING);
  assign wr_data      = bus_wr && (bus_addr == OFF_DATA);
  assign key_ok       = (key_q == UNLOCK_KEY);
  assign start_prog   = wr_data && !busy && key_ok;
  assign start_reload = (wr_ctrl || wr_set) && bus_wdata[RELOAD_BIT] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_sel_q <= '0;
      key_q      <= '0;
      err_q      <= 1'b0;
      t_prog_q   <= PROG_W'(DEF_PROG);
      t_relax_q  <= RELAX_W'(DEF_RELAX);
      t_read_q   <= READ_W'(DEF_READ);
      data_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        word_sel_q <= bus_wdata[AW-1:0];
        key_q      <= bus_wdata[KEY_LSB +: 16];
        err_q      <= err_q & bus_wdata[ERR_BIT];
      end
      if (wr_set) begin
        word_sel_q <= word_sel_q | bus_wdata[AW-1:0];
        key_q      <= key_q | bus_wdata[KEY_LSB +: 16];
        err_q      <= err_q | bus_wdata[ERR_BIT];
      end
      if (wr_tim) begin
        t_prog_q  <= bus_wdata[PROG_W-1:0];
        t_relax_q <= bus_wdata[TIM_RELAX_LSB +: RELAX_W];
        t_read_q  <= bus_wdata[TIM_READ_LSB +: READ_W];
      end
      if (wr_data) begin
        data_q <= bus_wdata;
        if (start_prog) key_q <= '0;
        else            err_q <= 1'b1;
      end
    end
  end

  // ---------------- sequencer and arrays ----------------
  otp_seq #(
    .WORDS(WORDS), .PROG_W(PROG_W), .RELAX_W(RELAX_W), .READ_W(READ_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .start_prog(start_prog), .start_reload(start_reload),
    .prog_addr(word_sel_q), .prog_data(bus_wdata),
    .t_prog(t_prog_q), .t_relax(t_relax_q), .t_read(t_read_q),
    .fuse_rdata(fuse_rdata),
    .busy(busy), .reloading(reloading), .word_addr(word_addr),
    .fuse_we(fuse_we), .fuse_wdata(fuse_wdata),
    .shadow_we(shadow_we), .shadow_wdata(shadow_wdata)
  );

  otp_mem #(.DEPTH(WORDS), .WIDTH(BUS_DW)) u_fuse (
    .clk(clk), .we(fuse_we), .waddr(word_addr), .wdata(fuse_wdata),
    .raddr(word_addr), .rdata(fuse_rdata)
  );

  // ---------------- read path ----------------
  logic [BUS_AW-1:0] sh_off;
  logic              sh_hit;
  assign sh_off = bus_addr - SHADOW_BASE;
  assign sh_hit = (bus_addr >= SHADOW_BASE) && ({1'b0, sh_off} < SH_SPAN)
                  && (bus_addr[3:0] == 4'h0);

  otp_mem #(.DEPTH(WORDS), .WIDTH(BUS_DW)) u_shadow (
    .clk(clk), .we(shadow_we), .waddr(word_addr), .wdata(shadow_wdata),
    .raddr(sh_off[AW+3:4]), .rdata(shadow_rdata)
  );

  logic [BUS_DW-1:0] ctrl_val, tim_val, reg_val;
  always_comb begin
    ctrl_val                   = '0;
    ctrl_val[AW-1:0]           = word_sel_q;
    ctrl_val[BUSY_BIT]         = busy;
    ctrl_val[ERR_BIT]          = err_q;
    ctrl_val[RELOAD_BIT]       = reloading;
    ctrl_val[KEY_LSB +: 16]    = key_q;
    tim_val                    = '0;
    tim_val[PROG_W-1:0]        = t_prog_q;
    tim_val[TIM_RELAX_LSB +: RELAX_W] = t_relax_q;
    tim_val[TIM_READ_LSB +: READ_W]   = t_read_q;
    case (bus_addr)
      OFF_CTRL, OFF_CTRL_SET: reg_val = ctrl_val;
      OFF_TIMING:             reg_val = tim_val;
      OFF_DATA:               reg_val = data_q;
      default:                reg_val = '0;
    endcase
  end

  logic              a_valid, a_sh;
  logic [BUS_DW-1:0] a_reg;
  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid    <= 1'b0;
      a_sh       <= 1'b0;
      a_reg      <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      a_valid    <= bus_rd;
      a_sh       <= sh_hit;
      a_reg      <= reg_val;
      bus_rvalid <= a_valid;
      bus_rdata  <= !a_valid ? '0 : (a_sh ? shadow_rdata : a_reg);
    end
  end

  // ---------------- assertions ----------------
  p_prog_start_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !busy && key_q == UNLOCK_KEY) |=> busy);

  p_shadow_reload_only_r4: assert property (@(posedge clk) disable iff (rst)
    shadow_we |-> (reloading && !fuse_we));

  p_bad_key_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !busy && key_q != UNLOCK_KEY) |=> (err_q && !busy));

  p_busy_reject_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_data && busy) |=> err_q);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[ERR_BIT]) |=> !err_q);

  p_key_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !busy && key_q == UNLOCK_KEY) |=> (key_q == '0));

  p_reload_selfclear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(reloading) |-> !busy);
endmodule

// File: tb/sim_otp_ctrl.sv
module sim_otp_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  always #10 clk = ~clk;

  otp_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  localparam logic [11:0] A_CTRL = 12'h000, A_SET = 12'h004,
                          A_TIM = 12'h010, A_DATA = 12'h020;
  localparam int PROG_LEN   = 2 * (1 + 1) + (5 + 1);
  localparam int RELOAD_LEN = 128 * (2 * (1 + 1) + (2 + 1));

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [11:0] sh(input int n);
    return 12'(12'h400 + n * 16);
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Monitor: pops the expected item for each returned read.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, 32'h0000_0000, "R1 control after reset");
    rd(A_TIM,  32'h0002_1005, "R1 timing after reset");
    rd(A_DATA, 32'h0000_0000, "R1 data after reset");
    rd(sh(0),  32'h0000_0000, "R1 shadow 0 after reset");

    // R11 timing field widths
    wr(A_TIM, 32'hFFFF_FFFF);
    rd(A_TIM, 32'h003F_FFFF, "R11 timing upper bits read 0");
    wr(A_TIM, 32'h0002_1005);
    rd(A_TIM, 32'h0002_1005, "R11 timing restored");

    // R2 set alias ORs fields
    wr(A_CTRL, 32'h0000_0005);
    wr(A_SET,  32'h3E77_0002);
    rd(A_CTRL, 32'h3E77_0007, "R2 set alias OR");

    // R3 / R10 / R8: program word 7, reads every cycle count busy length
    wr(A_DATA, 32'h0000_00A5);
    for (int i = 0; i < PROG_LEN; i++) rd(A_CTRL, 32'h0000_0107, "R3 R10 busy during program");
    rd(A_CTRL, 32'h0000_0007, "R8 R10 idle and key cleared after program");

    // R4 shadow unchanged before reload
    rd(sh(7), 32'h0000_0000, "R4 shadow unchanged before reload");

    // R5 wrong key (cleared) sets error, no busy
    wr(A_DATA, 32'h0000_005A);
    rd(A_CTRL, 32'h0000_0207, "R5 error without busy on bad key");

    // R7 error clear semantics
    wr(A_CTRL, 32'h0000_0207);
    rd(A_CTRL, 32'h0000_0207, "R7 error kept when bit9 written 1");
    wr(A_CTRL, 32'h0000_0007);
    rd(A_CTRL, 32'h0000_0007, "R7 error cleared when bit9 written 0");

    // further programs (R4 OR behaviour on word 7)
    wr(A_CTRL, 32'h3E77_0007); wr(A_DATA, 32'h0000_0F00); idle(PROG_LEN + 2);
    wr(A_CTRL, 32'h3E77_0000); wr(A_DATA, 32'h1234_5678); idle(PROG_LEN + 2);
    wr(A_CTRL, 32'h3E77_007F); wr(A_DATA, 32'h8000_0001); idle(PROG_LEN + 2);

    // R6 data write while busy rejected
    wr(A_CTRL, 32'h3E77_0003);
    wr(A_DATA, 32'h0000_0011);
    wr(A_SET,  32'h3E77_0000);
    wr(A_DATA, 32'h0000_0022);
    rd(A_CTRL, 32'h3E77_0303, "R6 error set while busy");
    idle(PROG_LEN + 2);
    rd(A_CTRL, 32'h3E77_0203, "R6 operation finished, key kept");
    wr(A_CTRL, 32'h0000_0000);
    rd(A_CTRL, 32'h0000_0000, "R7 control cleared");

    // R9 reload
    wr(A_SET, 32'h0000_0400);
    rd(A_CTRL, 32'h0000_0500, "R9 reload and busy set");
    idle(RELOAD_LEN + 4);
    rd(A_CTRL, 32'h0000_0000, "R9 reload bit self-cleared");
    rd(sh(0),   32'h1234_5678, "R9 shadow 0 after reload");
    rd(sh(3),   32'h0000_0011, "R6 word 3 holds only first data");
    rd(sh(7),   32'h0000_0FA5, "R4 fuse ORed, shadow 7 after reload");
    rd(sh(127), 32'h8000_0001, "R12 last shadow at 0xBF0");
    rd(sh(1),   32'h0000_0000, "R9 unprogrammed shadow 1");

    // R12 unmapped and unaligned offsets
    rd(12'h474, 32'h0000_0000, "R12 unaligned in window reads 0");
    rd(12'hC00, 32'h0000_0000, "R12 past window reads 0");
    rd(12'h008, 32'h0000_0000, "R12 unmapped register reads 0");
    wr(sh(7),  32'hFFFF_FFFF);
    wr(12'h030, 32'hFFFF_FFFF);
    rd(sh(7),  32'h0000_0FA5, "R12 write to shadow window ignored");
    rd(A_CTRL, 32'h0000_0000, "R12 unmapped write ignored");
    rd(A_TIM,  32'h0002_1005, "R12 timing untouched by unmapped write");

    idle(6);
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL R12 reads lost: actual %0d pending expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule